// File: doc/BRIEF.md
# Auxiliary Packet Slot Scheduler

This block keeps a small bank of software-loaded auxiliary packets and decides when each one goes out on the link. Each slot holds one header word and seven 32-bit payload words. Software writes these words through a plain register port. A single shared configuration register holds a 2-bit repetition mode for every slot. Strobes from the video timing side, one at the start of each field and one at the start of each frame, make slots due. Due slots are sent one at a time as a byte stream on a valid/ready output. Encoding, guard bands, error correction and checksum generation are done by other logic.

The transmit controller has three named states. `ST_IDLE` waits for a grant. The transition *launch* (IDLE to HEADER) happens when the arbiter grants a pending slot; on that edge all eight words of the slot are copied into a shadow buffer. `ST_HEADER` sends the three header bytes. The transition *header_done* (HEADER to PAYLOAD) happens when the third header byte is accepted. `ST_PAYLOAD` sends the 28 payload bytes. The transition *packet_done* (PAYLOAD to IDLE) happens when the final byte is accepted. This completion also turns a single-shot slot off. The controller always spends at least one cycle in IDLE between packets.

Top module: `pkt_slot_sched`

## Requirements
- R1: After reset, `tx_valid` is 0, every mode field is 0, no slot is pending, and all header and payload words read 0.
- R2: The mode of slot n (n = 1..6) is held in configuration bits [(n-1)*4+1 : (n-1)*4]. The two upper bits of each nibble, and bits 31:24, read as 0. Mode codes: 0 off, 1 single shot, 2 every field, 3 every frame.
- R3: A slot whose mode is 0 never starts a packet. Writing mode 0 to a pending slot cancels its pending send.
- R4: Writing mode 1 to a slot makes it pending at once. When its last byte has been accepted, the hardware clears its mode to 0, and no later strobe sends it again.
- R5: A mode-2 slot becomes pending on every field-start strobe and on every frame-start strobe. It sends exactly one packet per strobe.
- R6: A mode-3 slot becomes pending only on frame-start strobes. Field-start strobes have no effect on it.
- R7: When several slots are pending, the lowest-numbered one is sent first. Only one slot is granted at a time.
- R8: A packet is 31 bytes long, sent in this order:
  - header bits [7:0] (type);
  - header bits [15:8] (version);
  - header bits [19:16] zero-extended (length);
  - payload words 0 to 6, each word sent from bits [7:0] upward.

  The checksum byte in word 0 bits [7:0] is sent as stored. `tx_last` is high only on byte 31. `tx_slot` gives the slot number (1..6) for every byte.
- R9: A packet that has started always completes with the contents the slot held at launch. This holds even if the slot's words are rewritten, or its mode is cleared, while the packet is in flight.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data`, `tx_last` and `tx_slot` hold their values.
- R11: Register map:
  - address 0 is the configuration register;
  - the header of slot n is at address 8n;
  - payload word k of slot n is at address 8n+1+k.

  A header read returns bits [19:0] with bits [31:20] as 0. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data at `reg_addr` |
| field_start | input | 1 | One-cycle pulse at each video field start |
| frame_start | input | 1 | One-cycle pulse at each video frame start |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Sink accepts the byte |
| tx_data | output | 8 | Packet byte |
| tx_last | output | 1 | Final byte of the packet |
| tx_slot | output | 3 | Slot number being sent |

## Verification
The assertions assume that the sink obeys valid/ready: `tx_ready` may change at any time, but a byte counts as accepted only in a cycle where both `tx_valid` and `tx_ready` are high. They also assume that the strobes and register writes are synchronous pulses on `clk`. The stimulus drives every input on the falling edge and raises `tx_ready` for exactly one cycle per byte it accepts. It also keeps `tx_ready` low across the register writes that are made in the middle of a packet, so the hold property is exercised under a real stall. Strobes are issued only after the expected packets of earlier steps have been fully received. As a result, every packet can be attributed to one strobe or one mode write.

// File: rtl/pkt_slot_pkg.sv
package pkt_slot_pkg;
    localparam logic [1:0] MODE_OFF   = 2'd0;
    localparam logic [1:0] MODE_ONCE  = 2'd1;
    localparam logic [1:0] MODE_FIELD = 2'd2;
    localparam logic [1:0] MODE_FRAME = 2'd3;

    localparam int HDR_BYTES = 3;
    localparam int HDR_BITS  = 20;
    localparam int NIBBLE    = 4;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_HEADER  = 2'd1,
        ST_PAYLOAD = 2'd2
    } tx_state_e;
endpackage

// File: rtl/pkt_slot_regs.sv
module pkt_slot_regs
    import pkt_slot_pkg::*;
#(
    parameter int NS    = 6,
    parameter int NW    = 7,
    parameter int OFS_W = 3,
    parameter int SW    = 3,
    parameter int AW    = 6
)(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [AW-1:0]                 addr,
    input  logic [31:0]                   wdata,
    output logic [31:0]                   rdata,
    input  logic                          done,
    input  logic [SW-1:0]                 done_slot,
    output logic [NS-1:0][1:0]            mode_o,
    output logic [NS-1:0]                 arm_o,
    output logic [NS-1:0][HDR_BITS-1:0]   hdr_o,
    output logic [NS-1:0][NW-1:0][31:0]   pay_o
);
    logic [NS-1:0][1:0]          mode_q;
    logic [NS-1:0][HDR_BITS-1:0] hdr_q;
    logic [NS-1:0][NW-1:0][31:0] pay_q;

    logic [SW-1:0]    sel;
    logic [OFS_W-1:0] word;
    logic             sel_ok;
    logic             cfg_hit;
    logic [SW-1:0]    sel_idx;
    logic [OFS_W-1:0] word_idx;
    logic [SW-1:0]    done_idx;

    assign sel      = addr[AW-1:OFS_W];
    assign word     = addr[OFS_W-1:0];
    assign cfg_hit  = (addr == '0);
    assign sel_ok   = (sel != '0) && (sel <= SW'(NS));
    assign sel_idx  = sel - SW'(1);
    assign word_idx = word - OFS_W'(1);
    assign done_idx = done_slot - SW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            hdr_q  <= '0;
            pay_q  <= '0;
        end else begin
            if (done && mode_q[done_idx] == MODE_ONCE)
                mode_q[done_idx] <= MODE_OFF;
            if (wr_en) begin
                if (cfg_hit) begin
                    for (int i = 0; i < NS; i++)
                        mode_q[i] <= wdata[i*NIBBLE +: 2];
                end else if (sel_ok) begin
                    if (word == '0)
                        hdr_q[sel_idx] <= wdata[HDR_BITS-1:0];
                    else if (word <= OFS_W'(NW))
                        pay_q[sel_idx][word_idx] <= wdata;
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (cfg_hit) begin
            for (int i = 0; i < NS; i++)
                rdata[i*NIBBLE +: 2] = mode_q[i];
        end else if (sel_ok) begin
            if (word == '0)
                rdata[HDR_BITS-1:0] = hdr_q[sel_idx];
            else if (word <= OFS_W'(NW))
                rdata = pay_q[sel_idx][word_idx];
        end
    end

    for (genvar g = 0; g < NS; g++) begin : g_arm
        assign arm_o[g] = wr_en && cfg_hit && (wdata[g*NIBBLE +: 2] == MODE_ONCE);
    end

    assign mode_o = mode_q;
    assign hdr_o  = hdr_q;
    assign pay_o  = pay_q;
endmodule

// File: rtl/pkt_slot_arb.sv
module pkt_slot_arb
    import pkt_slot_pkg::*;
#(
    parameter int NS = 6,
    parameter int SW = 3
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NS-1:0][1:0] mode_i,
    input  logic [NS-1:0]      arm_i,
    input  logic               field_stb,
    input  logic               frame_stb,
    input  logic               idle_i,
    output logic [NS-1:0]      grant_o,
    output logic [SW-1:0]      grant_slot_o,
    output logic [NS-1:0]      active_o
);
    logic [NS-1:0] pend_q;
    logic [NS-1:0] pend_d;
    logic [NS-1:0] elig;

    for (genvar g = 0; g < NS; g++) begin : g_slot
        logic p_nxt;
        assign active_o[g] = (mode_i[g] != MODE_OFF);
        always_comb begin
            p_nxt = pend_q[g];
            if (grant_o[g])
                p_nxt = 1'b0;
            if (mode_i[g] == MODE_OFF)
                p_nxt = 1'b0;
            if (field_stb && mode_i[g] == MODE_FIELD)
                p_nxt = 1'b1;
            if (frame_stb && (mode_i[g] == MODE_FIELD || mode_i[g] == MODE_FRAME))
                p_nxt = 1'b1;
            if (arm_i[g])
                p_nxt = 1'b1;
        end
        assign pend_d[g] = p_nxt;
    end

    assign elig = pend_q & active_o;

    always_comb begin
        grant_o      = '0;
        grant_slot_o = '0;
        if (idle_i) begin
            for (int i = 0; i < NS; i++) begin
                if (elig[i] && grant_o == '0) begin
                    grant_o[i]   = 1'b1;
                    grant_slot_o = SW'(i + 1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end
endmodule

// File: rtl/pkt_slot_tx.sv
module pkt_slot_tx
    import pkt_slot_pkg::*;
#(
    parameter int NS = 6,
    parameter int NW = 7,
    parameter int SW = 3
)(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic [SW-1:0]                 start_slot_i,
    input  logic [NS-1:0][HDR_BITS-1:0]   hdr_i,
    input  logic [NS-1:0][NW-1:0][31:0]   pay_i,
    output logic                          tx_valid,
    input  logic                          tx_ready,
    output logic [7:0]                    tx_data,
    output logic                          tx_last,
    output logic [SW-1:0]                 tx_slot,
    output logic                          idle_o,
    output logic                          done_o
);
    localparam int PKT_BYTES = HDR_BYTES + 4 * NW;
    localparam int IDX_W     = $clog2(PKT_BYTES);

    tx_state_e               state_q, state_d;
    logic [IDX_W-1:0]        idx_q;
    logic [SW-1:0]           slot_q;
    logic [HDR_BITS-1:0]     sh_hdr;
    logic [NW-1:0][31:0]     sh_pay;
    logic [SW-1:0]           start_idx;
    logic [IDX_W-1:0]        p;
    logic                    fire;
    logic                    at_hdr_end;
    logic                    at_pkt_end;

    assign start_idx  = start_slot_i - SW'(1);
    assign fire       = tx_valid && tx_ready;
    assign at_hdr_end = (idx_q == IDX_W'(HDR_BYTES - 1));
    assign at_pkt_end = (idx_q == IDX_W'(PKT_BYTES - 1));
    assign p          = idx_q - IDX_W'(HDR_BYTES);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i)              state_d = ST_HEADER;
            ST_HEADER:  if (fire && at_hdr_end)   state_d = ST_PAYLOAD;
            ST_PAYLOAD: if (fire && at_pkt_end)   state_d = ST_IDLE;
            default:                              state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            slot_q <= '0;
            sh_hdr <= '0;
            sh_pay <= '0;
        end else if (state_q == ST_IDLE && start_i) begin
            idx_q  <= '0;
            slot_q <= start_slot_i;
            sh_hdr <= hdr_i[start_idx];
            sh_pay <= pay_i[start_idx];
        end else if (fire) begin
            idx_q <= idx_q + IDX_W'(1);
        end
    end

    always_comb begin
        tx_valid = 1'b0;
        tx_data  = '0;
        tx_last  = 1'b0;
        idle_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: idle_o = 1'b1;
            ST_HEADER: begin
                tx_valid = 1'b1;
                if (idx_q == IDX_W'(0))      tx_data = sh_hdr[7:0];
                else if (idx_q == IDX_W'(1)) tx_data = sh_hdr[15:8];
                else                         tx_data = {4'b0000, sh_hdr[19:16]};
            end
            ST_PAYLOAD: begin
                tx_valid = 1'b1;
                tx_data  = sh_pay[p[IDX_W-1:2]][{p[1:0], 3'b000} +: 8];
                tx_last  = at_pkt_end;
            end
            default: idle_o = 1'b1;
        endcase
    end

    assign tx_slot = slot_q;
    assign done_o  = fire && (state_q == ST_PAYLOAD) && at_pkt_end;
endmodule

// File: rtl/pkt_slot_sched.sv
module pkt_slot_sched
    import pkt_slot_pkg::*;
#(
    parameter int NUM_SLOTS = 6,
    parameter int PAY_WORDS = 7,
    localparam int OFS_W  = $clog2(PAY_WORDS + 1),
    localparam int SLOT_W = $clog2(NUM_SLOTS + 1),
    localparam int ADDR_W = OFS_W + SLOT_W
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              field_start,
    input  logic              frame_start,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic [SLOT_W-1:0] tx_slot
);
    logic [NUM_SLOTS-1:0][1:0]                 mode_w;
    logic [NUM_SLOTS-1:0]                      arm_w;
    logic [NUM_SLOTS-1:0][HDR_BITS-1:0]        hdr_w;
    logic [NUM_SLOTS-1:0][PAY_WORDS-1:0][31:0] pay_w;
    logic [NUM_SLOTS-1:0]                      grant_w;
    logic [NUM_SLOTS-1:0]                      active_w;
    logic [SLOT_W-1:0]                         gslot_w;
    logic                                      idle_w;
    logic                                      done_w;

    pkt_slot_regs #(
        .NS(NUM_SLOTS), .NW(PAY_WORDS), .OFS_W(OFS_W), .SW(SLOT_W), .AW(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
        .done(done_w), .done_slot(tx_slot),
        .mode_o(mode_w), .arm_o(arm_w), .hdr_o(hdr_w), .pay_o(pay_w)
    );

    pkt_slot_arb #(.NS(NUM_SLOTS), .SW(SLOT_W)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .mode_i(mode_w), .arm_i(arm_w),
        .field_stb(field_start), .frame_stb(frame_start),
        .idle_i(idle_w),
        .grant_o(grant_w), .grant_slot_o(gslot_w), .active_o(active_w)
    );

    pkt_slot_tx #(.NS(NUM_SLOTS), .NW(PAY_WORDS), .SW(SLOT_W)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .start_i(|grant_w), .start_slot_i(gslot_w),
        .hdr_i(hdr_w), .pay_i(pay_w),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_last(tx_last), .tx_slot(tx_slot),
        .idle_o(idle_w), .done_o(done_w)
    );
endmodule

// File: rtl/pkt_slot_sched_chk.sv
module pkt_slot_sched_chk #(
    parameter int NS = 6,
    localparam int SW = $clog2(NS + 1)
)(
    input logic          clk,
    input logic          rst_n,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic [7:0]    tx_data,
    input logic          tx_last,
    input logic [SW-1:0] tx_slot,
    input logic [NS-1:0] grant,
    input logic [NS-1:0] active
);
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last) && $stable(tx_slot)));

    assert_one_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_grant_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~active) == '0);

    assert_gap_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last) |=> !tx_valid);

    assert_first_not_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> !tx_last);

    assert_slot_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_slot >= SW'(1) && tx_slot <= SW'(NS)));
endmodule

bind pkt_slot_sched pkt_slot_sched_chk #(.NS(NUM_SLOTS)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last), .tx_slot(tx_slot),
    .grant(grant_w), .active(active_w)
);

// File: tb/sim_pkt_slot_sched.sv
module sim_pkt_slot_sched;
    localparam int CLK_PERIOD = 10;
    localparam int PKT = 31;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        reg_wr = 0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        field_start = 0;
    logic        frame_start = 0;
    logic        tx_valid;
    logic        tx_ready = 0;
    logic [7:0]  tx_data;
    logic        tx_last;
    logic [2:0]  tx_slot;

    int checks = 0;
    int failures = 0;

    logic [19:0] m_hdr [1:6];
    logic [31:0] m_pay [1:6][0:6];
    logic [7:0]  exp_pkt [0:PKT-1];

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_slot_sched u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .field_start(field_start), .frame_start(frame_start),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_last(tx_last), .tx_slot(tx_slot)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic reg_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic load_slot(input int s, input logic [7:0] seed);
        logic [31:0] hw;
        hw = {12'hFA5, 4'(seed[3:0]), seed ^ 8'h5C, seed + 8'h80};
        m_hdr[s] = hw[19:0];
        reg_write({3'(s), 3'd0}, hw);
        for (int k = 0; k < 7; k++) begin
            m_pay[s][k] = {seed + 8'(4*k+3), seed + 8'(4*k+2), seed + 8'(4*k+1), seed ^ 8'(k*17)};
            reg_write({3'(s), 3'(k + 1)}, m_pay[s][k]);
        end
    endtask

    task automatic build_expected(input int s);
        exp_pkt[0] = m_hdr[s][7:0];
        exp_pkt[1] = m_hdr[s][15:8];
        exp_pkt[2] = {4'b0000, m_hdr[s][19:16]};
        for (int k = 3; k < PKT; k++)
            exp_pkt[k] = m_pay[s][(k-3)/4][((k-3)%4)*8 +: 8];
    endtask

    task automatic get_byte(output logic [7:0] d, output logic l, output logic [2:0] s, output bit ok);
        ok = 0; d = '0; l = 0; s = '0;
        for (int t = 0; t < 300; t++) begin
            @(negedge clk);
            if (tx_valid) begin ok = 1; break; end
        end
        if (ok) begin
            d = tx_data; l = tx_last; s = tx_slot;
            tx_ready = 1;
            @(negedge clk);
            tx_ready = 0;
        end
    endtask

    // receives bytes [from, to] and counts mismatches against exp_pkt
    task automatic recv_range(input int s, input int from, input int to, inout int errs, input string req);
        logic [7:0] d; logic l; logic [2:0] sl; bit ok;
        for (int k = from; k <= to; k++) begin
            get_byte(d, l, sl, ok);
            if (!ok || d != exp_pkt[k] || l != (k == PKT-1) || sl != 3'(s)) begin
                if (errs == 0)
                    $display("  mismatch %s byte %0d: data=%0h/%0h last=%0b slot=%0d", req, k, d, exp_pkt[k], l, sl);
                errs++;
            end
        end
    endtask

    task automatic recv_packet(input int s, input string req);
        int errs = 0;
        build_expected(s);
        recv_range(s, 0, PKT-1, errs, req);
        check(errs == 0, req, 32'(errs), 32'(0));
    endtask

    task automatic expect_quiet(input int n, input string req);
        bit seen = 0;
        for (int t = 0; t < n; t++) begin
            @(negedge clk);
            if (tx_valid) seen = 1;
        end
        check(!seen, req, 32'(seen), 32'(0));
    endtask

    task automatic pulse_field();
        @(negedge clk); field_start = 1;
        @(negedge clk); field_start = 0;
    endtask

    task automatic pulse_frame();
        @(negedge clk); frame_start = 1;
        @(negedge clk); frame_start = 0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        @(negedge clk);
        check(tx_valid == 0, "R1 valid after reset", 32'(tx_valid), 32'(0));
        reg_read(6'd0, d);
        check(d == 0, "R1 config after reset", d, 0);
        reg_read({3'd1, 3'd0}, d);
        check(d == 0, "R1 header after reset", d, 0);
        expect_quiet(20, "R1 no output after reset");
    endtask

    task automatic t_regmap();
        logic [31:0] d;
        reg_write(6'd0, 32'hFFFF_FFFF);
        reg_read(6'd0, d);
        check(d == 32'h0033_3333, "R2 config reserved bits", d, 32'h0033_3333);
        reg_write(6'd0, 32'h0002_0000);
        reg_read(6'd0, d);
        check(d == 32'h0002_0000, "R2 slot5 field position", d, 32'h0002_0000);
        reg_write(6'd0, 32'h0);
        load_slot(4, 8'h21);
        reg_read({3'd4, 3'd0}, d);
        check(d == {12'h0, m_hdr[4]}, "R11 header read masks upper bits", d, {12'h0, m_hdr[4]});
        reg_read({3'd4, 3'd7}, d);
        check(d == m_pay[4][6], "R11 payload word 6 read", d, m_pay[4][6]);
        reg_read({3'd7, 3'd2}, d);
        check(d == 0, "R11 unmapped read", d, 0);
    endtask

    task automatic t_once();
        logic [31:0] d;
        load_slot(2, 8'h40);
        reg_write(6'd0, 32'h0000_0010);
        recv_packet(2, "R4 R8 single shot packet");
        reg_read(6'd0, d);
        check(d == 0, "R4 mode cleared after send", d, 0);
        pulse_field();
        pulse_frame();
        expect_quiet(60, "R4 no resend after clear");
    endtask

    task automatic t_field();
        load_slot(1, 8'h90);
        reg_write(6'd0, 32'h0000_0002);
        expect_quiet(20, "R5 idle before strobe");
        pulse_field();
        recv_packet(1, "R5 field strobe send");
        expect_quiet(60, "R5 exactly one per field");
        pulse_frame();
        recv_packet(1, "R5 frame strobe send");
        expect_quiet(60, "R5 exactly one per frame");
    endtask

    task automatic t_frame();
        load_slot(3, 8'hC3);
        reg_write(6'd0, 32'h0000_0300);
        pulse_field();
        expect_quiet(60, "R6 field strobe ignored");
        pulse_frame();
        recv_packet(3, "R6 frame strobe send");
        expect_quiet(60, "R6 one per frame");
    endtask

    task automatic t_off();
        reg_write(6'd0, 32'h0);
        pulse_field();
        pulse_frame();
        expect_quiet(60, "R3 all modes off no send");
    endtask

    task automatic t_priority();
        reg_write(6'd0, 32'h0000_0332);
        pulse_frame();
        recv_packet(1, "R7 first slot1");
        recv_packet(2, "R7 second slot2");
        recv_packet(3, "R7 third slot3");
        expect_quiet(60, "R7 nothing further");
    endtask

    task automatic t_drop();
        int errs = 0;
        load_slot(6, 8'h66);
        reg_write(6'd0, 32'h0030_0002);
        pulse_frame();
        build_expected(1);
        recv_range(1, 0, 1, errs, "R3 drop");
        reg_write(6'd0, 32'h0000_0002);
        recv_range(1, 2, PKT-1, errs, "R3 drop");
        check(errs == 0, "R3 blocking packet intact", 32'(errs), 0);
        expect_quiet(80, "R3 cleared pending slot6 not sent");
    endtask

    task automatic t_snapshot();
        int errs = 0;
        logic [7:0] hold;
        logic [31:0] d;
        reg_write(6'd0, 32'h0);
        load_slot(4, 8'h17);
        reg_write(6'd0, 32'h0000_1000);
        build_expected(4);
        recv_range(4, 0, 4, errs, "R9 snapshot");
        @(negedge clk);
        hold = tx_data;
        reg_write(6'd0, 32'h0);
        reg_write({3'd4, 3'd0}, 32'h000E_EEEE);
        for (int k = 0; k < 7; k++)
            reg_write({3'd4, 3'(k + 1)}, 32'hDEAD_BEEF);
        @(negedge clk);
        check(tx_valid && tx_data == hold, "R10 byte held during stall", {23'h0, tx_valid, tx_data}, {24'h1, hold});
        recv_range(4, 5, PKT-1, errs, "R9 snapshot");
        check(errs == 0, "R9 in-flight packet uses launch contents", 32'(errs), 0);
        reg_read({3'd4, 3'd1}, d);
        check(d == 32'hDEAD_BEEF, "R11 rewritten word stored", d, 32'hDEAD_BEEF);
        expect_quiet(60, "R9 no send after mode cleared");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_regmap();
        t_once();
        t_field();
        t_frame();
        t_off();
        t_priority();
        t_drop();
        t_snapshot();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule